// File: doc/BRIEF.md
# Indexed Clock Register Bank with Interrupt Flags

This block is the software-visible face of a real-time clock: a 128-byte register space that a processor reaches through a two-location port. A write to the even location latches a 7-bit pointer. Accesses to the odd location then read or write the byte that the pointer selects. Four bytes in the space are control registers, not plain storage. The first holds the rate and oscillator fields and an update-in-progress flag. The second holds the mode bits and the three interrupt enables. The third holds the interrupt flags and is cleared when it is read. The fourth is a fixed status byte.

The block sits between the bus and a separate calendar counter, and it does no calendar arithmetic. Seven bytes hold the time and date fields. They are presented to the calendar as one packed vector. When software changes them, a one-cycle `cal_load` pulse tells the calendar to reload. After each tick the calendar copies its fields back with `cal_copy`. Three event sources (periodic, alarm and update-ended) ask for flags to be set. Each request is gated by its enable bit, and the interrupt line follows the summary flag.

Top module: `rtc_regbank`

## Requirements
- R1: A write with `bus_addr`=0 stores `bus_wdata[6:0]` as the index, and bit 7 is dropped. A read with `bus_addr`=0 returns 0xFF.
- R2: With `bus_addr`=1, a write stores `bus_wdata` in the byte at the current index and a read returns that byte. This covers every index outside 10 to 13 in the 128-byte space.
- R3: Writes to index 12 (flags) and index 13 (status) change nothing.
- R4: Bit 7 of index 10 (UIP) cannot be written. A write to index 10 keeps UIP and replaces bits 6..0. A `uip_set` pulse sets UIP only while SET (bit 7 of index 11) is 0.
- R5: A write to index 11 with bit 7 (SET) high clears UIP and stores bit 4 (UIE) as 0. All other bits are stored as written.
- R6: The time fields are at indices 0, 2, 4, 6, 7, 8 and 9, packed in that order into `cal_fields` and `cal_time` with field k at bits [8k+7:8k]. A write to one of them while SET is 0 raises `cal_load` for exactly the cycle after the write edge. While SET is 1 the same write raises no pulse.
- R7: A write to index 11 with bit 7 low raises `cal_load` (same timing as R6) if SET was 1 before the write, and does not if it was 0.
- R8: A read of index 12 returns the flag byte as it was before the read. The byte then becomes 0x00 and `irq` falls.
- R9: The flag byte is index 12. Bit 6 is periodic, set by `periodic_req` when B bit 6 = 1. Bit 5 is alarm, set by `alarm_req` when B bit 5 = 1. Bit 4 is update-ended, set by `update_req` when B bit 4 = 1. Any accepted request also sets bit 7. A request whose enable is 0 is ignored.
- R10: A request accepted in the same cycle as a read of index 12 is not lost: the next read returns it.
- R11: `irq` equals bit 7 of the flag byte at all times.
- R12: After reset, index 10 = 0x26, index 11 = 0x02, index 12 = 0x00, index 13 = 0x80, and all other bytes and the index are 0.
- R13: While SET is 0, a `cal_copy` pulse loads the seven time fields from `cal_time` and clears UIP. While SET is 1, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| periodic_req | input | 1 | Periodic flag request |
| alarm_req | input | 1 | Alarm flag request |
| update_req | input | 1 | Update-ended flag request |
| uip_set | input | 1 | Calendar update about to start |
| cal_copy | input | 1 | Calendar writes its fields back |
| cal_time | input | 56 | Calendar fields, packed as in R6 |
| cal_fields | output | 56 | Stored time fields, packed as in R6 |
| cal_load | output | 1 | Calendar must reload from `cal_fields` |
| ctrl_a | output | 8 | Control register A (index 10) |
| ctrl_b | output | 8 | Control register B (index 11) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong index or a misdecoded write shows up as a wrong byte on the next read of that location. The sweep writes and reads back every index, so it surfaces within two bus accesses. A flag or UIP error shows on `irq` or `ctrl_a` one cycle after the event. The clear-on-read path and the rule that keeps a request arriving during a read are visible on the next read of index 12. A lost or spurious reload request shows on `cal_load` in the single cycle after the triggering write, so each reload is checked in exactly that cycle.

// File: rtl/rtc_rb_pkg.sv
package rtc_rb_pkg;
   // control register locations (decoded by software and the calendar)
   localparam int unsigned IX_A = 10;
   localparam int unsigned IX_B = 11;
   localparam int unsigned IX_C = 12;
   localparam int unsigned IX_D = 13;
   localparam int unsigned N_TIME = 7;

   // bit positions
   localparam int unsigned A_UIP  = 7;
   localparam int unsigned B_SET  = 7;
   localparam int unsigned B_PIE  = 6;
   localparam int unsigned B_AIE  = 5;
   localparam int unsigned B_UIE  = 4;
   localparam int unsigned C_IRQF = 7;

   // position of a byte index inside the packed time vector, -1 if not a time field
   function automatic int time_slot(input int i);
      case (i)
         0: return 0;
         2: return 1;
         4: return 2;
         6: return 3;
         7: return 4;
         8: return 5;
         9: return 6;
         default: return -1;
      endcase
   endfunction

   // byte index of packed time slot k
   function automatic int slot_index(input int k);
      return (k < 3) ? 2 * k : k + 3;
   endfunction
endpackage

// File: rtl/rtc_rb_port.sv
module rtc_rb_port #(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs,
   input  logic             we,
   input  logic             addr_sel,
   input  logic [IDX_W-1:0] wdata_idx,
   output logic [IDX_W-1:0] idx,
   output logic             dat_wr,
   output logic             dat_rd
);
   if (IDX_W > 7 || IDX_W < 4) begin : g_bad_idx
      $error("rtc_rb_port: IDX_W must be 4..7");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (cs && we && !addr_sel)
         idx <= wdata_idx;
   end

   assign dat_wr = cs &&  we && addr_sel;
   assign dat_rd = cs && !we && addr_sel;
endmodule

// File: rtl/rtc_rb_store.sv
module rtc_rb_store
   import rtc_rb_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      idx,
   input  logic [7:0]            wdata,
   input  logic                  copy_en,
   input  logic [N_TIME*8-1:0]   cal_time,
   output logic [7:0]            rd_byte,
   output logic [N_TIME*8-1:0]   time_flat
);
   localparam int DEPTH = 1 << IDX_W;

   if (DEPTH <= int'(IX_D)) begin : g_bad_depth
      $error("rtc_rb_store: space too small for control registers");
   end

   logic [DEPTH-1:0][7:0] bytes_w;

   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      if (i >= int'(IX_A) && i <= int'(IX_D)) begin : g_hole
         assign bytes_w[i] = '0;
      end else begin : g_cell
         localparam int  SL   = time_slot(i);
         localparam int  SLI  = (SL < 0) ? 0 : SL;
         localparam bit  IS_T = (SL >= 0);
         logic [7:0] q;
         logic       load_b;
         assign load_b = IS_T && copy_en;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && idx == IDX_W'(i))
               q <= wdata;
            else if (load_b)
               q <= cal_time[SLI*8 +: 8];
         end
         assign bytes_w[i] = q;
      end
   end

   for (genvar k = 0; k < int'(N_TIME); k++) begin : g_pack
      assign time_flat[k*8 +: 8] = bytes_w[slot_index(k)];
   end

   assign rd_byte = bytes_w[idx];
endmodule

// File: rtl/rtc_rb_ctrl.sv
module rtc_rb_ctrl
   import rtc_rb_pkg::*;
#(
   parameter int         IDX_W   = 7,
   parameter logic [7:0] RESET_A = 8'h26,
   parameter logic [7:0] RESET_B = 8'h02,
   parameter logic [7:0] RESET_D = 8'h80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dat_wr,
   input  logic             dat_rd,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   input  logic             uip_set,
   input  logic             cal_copy,
   input  logic             periodic_req,
   input  logic             alarm_req,
   input  logic             update_req,
   output logic [7:0]       reg_a,
   output logic [7:0]       reg_b,
   output logic [7:0]       reg_c,
   output logic [7:0]       reg_d,
   output logic             copy_en,
   output logic             cal_load,
   output logic             irq
);
   localparam logic [IDX_W-1:0] SEL_A = IDX_W'(IX_A);
   localparam logic [IDX_W-1:0] SEL_B = IDX_W'(IX_B);
   localparam logic [IDX_W-1:0] SEL_C = IDX_W'(IX_C);

   if (RESET_A[A_UIP] != 1'b0) begin : g_bad_ra
      $error("rtc_rb_ctrl: RESET_A must start with UIP clear");
   end

   logic       wr_a, wr_b, rd_c, set_now, time_hit, reload;
   logic [2:0] src;
   logic [7:0] flags_new;
   logic [6:0] a_low;
   logic       uip;

   assign wr_a     = dat_wr && idx == SEL_A;
   assign wr_b     = dat_wr && idx == SEL_B;
   assign rd_c     = dat_rd && idx == SEL_C;
   assign set_now  = reg_b[B_SET];
   assign time_hit = time_slot(int'(idx)) >= 0;
   assign copy_en  = cal_copy && !set_now;

   // reload request: time write outside set mode, or leaving set mode
   assign reload = (dat_wr && time_hit && !set_now) ||
                   (wr_b && !wdata[B_SET] && set_now);

   // gated flag requests, bit order periodic/alarm/update
   assign src       = {periodic_req & reg_b[B_PIE],
                       alarm_req    & reg_b[B_AIE],
                       update_req   & reg_b[B_UIE]};
   assign flags_new = {|src, src, 4'b0000};

   // register A: lower bits from the bus, UIP from calendar events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         a_low <= RESET_A[6:0];
      else if (wr_a)
         a_low <= wdata[6:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         uip <= RESET_A[A_UIP];
      else if (wr_b && wdata[B_SET])
         uip <= 1'b0;
      else if (copy_en)
         uip <= 1'b0;
      else if (uip_set && !set_now)
         uip <= 1'b1;
   end

   assign reg_a = {uip, a_low};

   // register B: entering set mode masks the update-ended enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_b <= RESET_B;
      else if (wr_b)
         reg_b <= wdata[B_SET] ? (wdata & ~(8'h01 << B_UIE)) : wdata;
   end

   // register C: sticky flags, cleared by a read, new requests survive the read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_c <= 8'h00;
      else if (rd_c)
         reg_c <= flags_new;
      else
         reg_c <= reg_c | flags_new;
   end

   // register D: fixed status, no write path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_d <= RESET_D;
      else
         reg_d <= reg_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cal_load <= 1'b0;
      else
         cal_load <= reload;
   end

   assign irq = reg_c[C_IRQF];
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
   import rtc_rb_pkg::*;
#(
   parameter int         IDX_W   = 7,
   parameter logic [7:0] RESET_A = 8'h26,
   parameter logic [7:0] RESET_B = 8'h02,
   parameter logic [7:0] RESET_D = 8'h80
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_cs,
   input  logic        bus_we,
   input  logic        bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic        periodic_req,
   input  logic        alarm_req,
   input  logic        update_req,
   input  logic        uip_set,
   input  logic        cal_copy,
   input  logic [55:0] cal_time,
   output logic [55:0] cal_fields,
   output logic        cal_load,
   output logic [7:0]  ctrl_a,
   output logic [7:0]  ctrl_b,
   output logic        irq
);
   localparam int TW = int'(N_TIME) * 8;

   if (TW != 56) begin : g_bad_tw
      $error("rtc_regbank: time vector width mismatch");
   end

   logic [IDX_W-1:0] idx_q;
   logic             dat_wr, dat_rd, copy_en;
   logic [7:0]       store_byte, reg_c, reg_d;

   rtc_rb_port #(.IDX_W(IDX_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (bus_cs),
      .we        (bus_we),
      .addr_sel  (bus_addr),
      .wdata_idx (bus_wdata[IDX_W-1:0]),
      .idx       (idx_q),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd)
   );

   rtc_rb_ctrl #(
      .IDX_W   (IDX_W),
      .RESET_A (RESET_A),
      .RESET_B (RESET_B),
      .RESET_D (RESET_D)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .dat_wr       (dat_wr),
      .dat_rd       (dat_rd),
      .idx          (idx_q),
      .wdata        (bus_wdata),
      .uip_set      (uip_set),
      .cal_copy     (cal_copy),
      .periodic_req (periodic_req),
      .alarm_req    (alarm_req),
      .update_req   (update_req),
      .reg_a        (ctrl_a),
      .reg_b        (ctrl_b),
      .reg_c        (reg_c),
      .reg_d        (reg_d),
      .copy_en      (copy_en),
      .cal_load     (cal_load),
      .irq          (irq)
   );

   rtc_rb_store #(.IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (dat_wr),
      .idx       (idx_q),
      .wdata     (bus_wdata),
      .copy_en   (copy_en),
      .cal_time  (cal_time),
      .rd_byte   (store_byte),
      .time_flat (cal_fields)
   );

   always_comb begin
      if (!bus_addr)
         bus_rdata = 8'hFF;
      else if (idx_q == IDX_W'(IX_A))
         bus_rdata = ctrl_a;
      else if (idx_q == IDX_W'(IX_B))
         bus_rdata = ctrl_b;
      else if (idx_q == IDX_W'(IX_C))
         bus_rdata = reg_c;
      else if (idx_q == IDX_W'(IX_D))
         bus_rdata = reg_d;
      else
         bus_rdata = store_byte;
   end
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
   parameter int IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_cs,
   input logic             bus_we,
   input logic             bus_addr,
   input logic [7:0]       bus_wdata,
   input logic [7:0]       bus_rdata,
   input logic             periodic_req,
   input logic             alarm_req,
   input logic             update_req,
   input logic             uip_set,
   input logic             cal_copy,
   input logic             cal_load,
   input logic [7:0]       ctrl_a,
   input logic [7:0]       ctrl_b,
   input logic             irq,
   input logic [IDX_W-1:0] idx
);
   logic wr_d, rd_d, any_req, at_a, at_b, at_c, at_time;
   assign wr_d    = bus_cs &&  bus_we && bus_addr;
   assign rd_d    = bus_cs && !bus_we && bus_addr;
   assign any_req = periodic_req || alarm_req || update_req;
   assign at_a    = idx == IDX_W'(10);
   assign at_b    = idx == IDX_W'(11);
   assign at_c    = idx == IDX_W'(12);
   assign at_time = idx == IDX_W'(0) || idx == IDX_W'(2) || idx == IDX_W'(4) ||
                    idx == IDX_W'(6) || idx == IDX_W'(7) || idx == IDX_W'(8) ||
                    idx == IDX_W'(9);

   p_even_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && !bus_we && !bus_addr) |-> bus_rdata == 8'hFF);

   p_c_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && at_c && !any_req) |=> $stable(irq));

   p_uip_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && at_a && !uip_set && !cal_copy) |=> ctrl_a[7] == $past(ctrl_a[7]));

   p_set_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && at_b && bus_wdata[7]) |=> (!ctrl_b[4] && !ctrl_a[7]));

   p_time_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && at_time && !ctrl_b[7]) |=> cal_load);

   p_leave_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && at_b && !bus_wdata[7] && ctrl_b[7]) |=> cal_load);

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_d && at_c && !any_req) |=> !irq);

   p_req_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_d && at_c && update_req && ctrl_b[4]) |=> irq);
endmodule

bind rtc_regbank rtc_regbank_chk #(.IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_cs       (bus_cs),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .periodic_req (periodic_req),
   .alarm_req    (alarm_req),
   .update_req   (update_req),
   .uip_set      (uip_set),
   .cal_copy     (cal_copy),
   .cal_load     (cal_load),
   .ctrl_a       (ctrl_a),
   .ctrl_b       (ctrl_b),
   .irq          (irq),
   .idx          (idx_q)
);

// File: tb/test_rtc_regbank.sv
module test_rtc_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        periodic_req = 1'b0, alarm_req = 1'b0, update_req = 1'b0;
   logic        uip_set = 1'b0, cal_copy = 1'b0;
   logic [55:0] cal_time = '0;
   logic [55:0] cal_fields;
   logic        cal_load, irq;
   logic [7:0]  ctrl_a, ctrl_b;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rtc_regbank i_rtc_regbank (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .periodic_req(periodic_req), .alarm_req(alarm_req), .update_req(update_req),
      .uip_set(uip_set), .cal_copy(cal_copy), .cal_time(cal_time),
      .cal_fields(cal_fields), .cal_load(cal_load), .ctrl_a(ctrl_a),
      .ctrl_b(ctrl_b), .irq(irq)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   function automatic bit is_time(input int i);
      return (i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_cs = 1'b0;
   endtask

   task automatic wr_reg(input int i, input logic [7:0] d);
      bus_wr(1'b0, 8'(i));
      bus_wr(1'b1, d);
   endtask

   task automatic rd_reg(input int i, output logic [7:0] d);
      bus_wr(1'b0, 8'(i));
      bus_rd(1'b1, d);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd_reg(10, v); check("R12 A", v, 8'h26);
      rd_reg(11, v); check("R12 B", v, 8'h02);
      rd_reg(12, v); check("R12 C", v, 8'h00);
      rd_reg(13, v); check("R12 D", v, 8'h80);
      rd_reg(20, v); check("R12 byte", v, 8'h00);
      check("R12 irq", irq, 0);
      check("R12 fields", cal_fields, 56'h0);
      bus_rd(1'b0, v); check("R1 even read", v, 8'hFF);

      // sweep: write every plain byte, check reload pulse
      for (int i = 0; i < 128; i++) begin
         if (i >= 10 && i <= 13) continue;
         wr_reg(i, pat(i));
         check($sformatf("R6 load idx %0d", i), cal_load, is_time(i));
      end
      for (int i = 0; i < 128; i++) begin
         if (i >= 10 && i <= 13) continue;
         rd_reg(i, v);
         check($sformatf("R2 idx %0d", i), v, pat(i));
      end
      for (int k = 0; k < 7; k++) begin
         int ix;
         ix = (k < 3) ? 2 * k : k + 3;
         check($sformatf("R6 pack %0d", k), cal_fields[k*8 +: 8], pat(ix));
      end

      // index keeps only 7 bits
      bus_wr(1'b0, 8'h80 | 8'd20);
      bus_rd(1'b1, v); check("R1 idx bit7 dropped", v, pat(20));

      // register A
      wr_reg(10, 8'h00); rd_reg(10, v); check("R4 A 00", v, 8'h00);
      wr_reg(10, 8'h55); rd_reg(10, v); check("R4 A 55", v, 8'h55);
      wr_reg(10, 8'hFF); rd_reg(10, v); check("R4 A FF", v, 8'h7F);
      wr_reg(10, 8'h7A); rd_reg(10, v); check("R4 A 7A", v, 8'h7A);
      pulse(uip_set);
      check("R4 uip set", ctrl_a, 8'hFA);
      wr_reg(10, 8'h11); rd_reg(10, v); check("R4 uip kept", v, 8'h91);

      // enter set mode
      wr_reg(11, 8'h92);
      check("R7 no load entering set", cal_load, 0);
      rd_reg(11, v); check("R5 uie masked", v, 8'h82);
      rd_reg(10, v); check("R5 uip cleared", v, 8'h11);
      pulse(uip_set);
      check("R4 uip blocked in set", ctrl_a, 8'h11);
      wr_reg(2, 8'h33);
      check("R6 no load in set", cal_load, 0);
      rd_reg(2, v); check("R2 time in set", v, 8'h33);
      wr_reg(11, 8'h02);
      check("R7 load on leave", cal_load, 1);
      wr_reg(11, 8'h02);
      check("R7 no load when clear", cal_load, 0);

      // read-only C and D
      wr_reg(12, 8'hFF); rd_reg(12, v); check("R3 C ignored", v, 8'h00);
      check("R3 irq after C write", irq, 0);
      wr_reg(13, 8'h00); rd_reg(13, v); check("R3 D ignored", v, 8'h80);

      // disabled requests
      @(negedge clk); periodic_req = 1; alarm_req = 1; update_req = 1;
      @(negedge clk); periodic_req = 0; alarm_req = 0; update_req = 0;
      check("R9 disabled irq", irq, 0);
      rd_reg(12, v); check("R9 disabled C", v, 8'h00);

      // enabled flags
      wr_reg(11, 8'h70);
      pulse(periodic_req);
      check("R11 irq on periodic", irq, 1);
      rd_reg(12, v); check("R8 C periodic", v, 8'hC0);
      check("R8 irq after read", irq, 0);
      rd_reg(12, v); check("R8 C cleared", v, 8'h00);
      @(negedge clk); alarm_req = 1; update_req = 1;
      @(negedge clk); alarm_req = 0; update_req = 0;
      rd_reg(12, v); check("R9 alarm+update", v, 8'hB0);
      check("R11 irq low", irq, 0);

      // request during read of C
      pulse(periodic_req);
      bus_wr(1'b0, 8'd12);
      @(negedge clk);
      bus_cs = 1; bus_we = 0; bus_addr = 1; update_req = 1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_cs = 0; update_req = 0;
      check("R10 read value", v, 8'hC0);
      check("R10 irq kept", irq, 1);
      rd_reg(12, v); check("R10 kept flag", v, 8'h90);

      // calendar copy
      pulse(uip_set);
      check("R4 uip set again", ctrl_a[7], 1);
      @(negedge clk);
      cal_time = 56'hA6A5A4A3A2A1A0; cal_copy = 1;
      @(negedge clk);
      cal_copy = 0;
      check("R13 uip cleared", ctrl_a, 8'h11);
      check("R13 fields", cal_fields, 56'hA6A5A4A3A2A1A0);
      rd_reg(0, v); check("R13 idx0", v, 8'hA0);
      rd_reg(9, v); check("R13 idx9", v, 8'hA6);
      rd_reg(1, v); check("R13 alarm byte untouched", v, pat(1));
      wr_reg(11, 8'hF0);
      rd_reg(11, v); check("R5 B set", v, 8'hE0);
      @(negedge clk);
      cal_time = 56'h11111111111111; cal_copy = 1;
      @(negedge clk);
      cal_copy = 0;
      rd_reg(4, v); check("R13 copy ignored in set", v, 8'hA2);
      wr_reg(11, 8'h70);
      check("R7 load after set", cal_load, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule